// File: doc/BRIEF.md
# Write Burst Data Strobe Sequencer

This block is the controller-side write data path for a double-data-rate memory write burst. When a write command pulse is accepted, it counts out the write latency, which is one clock shorter than the read latency, and brings the data and strobe outputs through a fixed sequence. The outputs are enabled for a lead-in clock. A low preamble follows, then one or more data clocks carrying two beats each with their byte masks. A low postamble closes the burst, and after it the bus is released. The data path, strobe, mask and output enable are modelled at clock granularity. Each data clock carries a rising-edge beat and a falling-edge beat. The strobe is shown as its level in the first half and in the second half of the clock.

A memory controller drives `cmd_i` for one clock per write and holds the latency and burst-length settings static while bursts are pending. One clock before each data clock the block raises `wrdy_o`. In that clock the controller presents both beats and their byte enables. The block registers them onto the pins for the following clock. A command issued exactly one burst duration after the previous one produces a continuous run of data clocks with no preamble or idle clock between the bursts.

Top module: `wr_burst_seq`

## Requirements
- R1: With additive latency `cfg_al_i` and CAS latency `cfg_cl_i`, the write latency is WL = AL + CL - 1. A command sampled in clock c gives its first data clock in clock c + WL. The settings must satisfy AL + CL >= 4.
- R2: In a data clock `dqs_o` is 2'b01: bit 0 is the first-half level (high), bit 1 is the second-half level (low). `dq_o[DQ_W-1:0]` is the beat taken on the rising strobe edge and `dq_o[2*DQ_W-1:DQ_W]` is the beat taken on the falling edge.
- R3: A burst occupies 2 data clocks when `cfg_bl8_i` is 0 (four beats) and 4 data clocks when it is 1 (eight beats).
- R4: The clock just before the first data clock of a run is a preamble: `oe_o` is high and `dqs_o` is 2'b00.
- R5: `oe_o` is already high, with `dqs_o` at 2'b00, two clocks before the first data clock of a run. This lead-in is one clock ahead of the preamble.
- R6: The clock after the last data clock of a run is a postamble with `oe_o` high and `dqs_o` 2'b00. In the clock after that, `oe_o` is low unless another burst's lead-in or preamble falls there.
- R7: `dm_o` is the bitwise inverse of the byte enables: bit b of `dm_o` masks byte b of `dq_o` (8 bits each), so a high mask bit means the byte is not written.
- R8: `wrdy_o` is high exactly in each clock that precedes a data clock. The data and byte enables presented in that clock appear on `dq_o` and the inverse of the enables on `dm_o` in the next clock.
- R9: A command issued BL/2 clocks after the previous one makes its first data clock follow the last data clock of the previous burst directly, with no preamble or postamble clock between them.
- R10: While `rst` is high and in the clock after it, `oe_o`, `wrdy_o` and `dqs_o` are low.
- R11: Whenever a clock is not a data clock, `dq_o` and `dm_o` are all zero. When `oe_o` is low, `dqs_o` is also zero, which models the released, high-impedance bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 1 | Write command accepted in this clock |
| cfg_bl8_i | input | 1 | Burst length select: 0 gives four beats, 1 gives eight beats |
| cfg_al_i | input | AL_W | Additive latency in clocks |
| cfg_cl_i | input | CL_W | CAS latency in clocks |
| wdata_i | input | 2*DQ_W | Two write beats; low half is the rising-edge beat |
| wbe_i | input | 2*DQ_W/8 | Active-high byte enables for both beats |
| wrdy_o | output | 1 | Data and enables are taken in this clock |
| dq_o | output | 2*DQ_W | Data lines, both beats of the clock |
| dm_o | output | 2*DQ_W/8 | Active-high byte masks, both beats |
| dqs_o | output | 2 | Strobe level: bit 0 first half, bit 1 second half |
| oe_o | output | 1 | Output enable for data, mask and strobe |

## Verification
The hardest case to reach is the junction between bursts. One variant is the seamless join, where the second command lands exactly one burst duration after the first. The other is the one-clock gap, where the postamble of one burst and the preamble of the next fall in the same clock. The stimulus issues commands with exact clock spacing for both burst lengths and at the smallest and largest latencies. An independent per-clock map of expected data clocks then predicts lead-in, preamble, data, postamble and idle for every clock, and a queue of the beats handed over on `wrdy_o` is compared in order against the pins.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEADIN,
        PH_PRE,
        PH_DATA,
        PH_POST
    } strobe_ph_e;

    typedef struct packed {
        logic       oe;
        logic [1:0] dqs;
    } strobe_t;

    localparam logic [1:0] DQS_TOGGLE = 2'b01;
    localparam logic [1:0] DQS_LOW    = 2'b00;

    function automatic strobe_t ph_to_strobe(strobe_ph_e ph);
        strobe_t s;
        unique case (ph)
            PH_IDLE: begin s.oe = 1'b0; s.dqs = DQS_LOW;    end
            PH_DATA: begin s.oe = 1'b1; s.dqs = DQS_TOGGLE; end
            default: begin s.oe = 1'b1; s.dqs = DQS_LOW;    end
        endcase
        return s;
    endfunction

    function automatic logic [2:0] burst_clocks(logic bl8);
        return bl8 ? 3'd4 : 3'd2;
    endfunction

endpackage

// File: rtl/wbs_sched.sv
module wbs_sched #(
    parameter int AL_W = 3,
    parameter int CL_W = 3,
    parameter int N    = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_i,
    input  logic            bl8_i,
    input  logic [AL_W-1:0] al_i,
    input  logic [CL_W-1:0] cl_i,
    output logic [N-1:0]    sched_q
);
    import wbs_pkg::*;

    localparam int LW = $clog2(N + 1) + 1;

    logic [LW-1:0] lo;
    logic [LW-1:0] hi;
    logic [N-1:0]  win;

    // Bit k of sched_q marks a data clock k clocks from now. A command lands
    // its window one clock later, so the first data index is WL-1 here.
    always_comb begin
        lo = LW'(al_i) + LW'(cl_i) - LW'(2);
        hi = lo + LW'(burst_clocks(bl8_i));
    end

    for (genvar k = 0; k < N; k++) begin : g_win
        assign win[k] = cmd_i && (LW'(k) >= lo) && (LW'(k) < hi);
    end

    always_ff @(posedge clk) begin
        if (rst) sched_q <= '0;
        else     sched_q <= (sched_q >> 1) | win;
    end

endmodule

// File: rtl/wbs_strobe_gen.sv
module wbs_strobe_gen (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        ahead_i,
    output wbs_pkg::strobe_t  strobe_o
);
    import wbs_pkg::*;

    logic       was_data_q;
    strobe_ph_e ph;

    always_ff @(posedge clk) begin
        if (rst) was_data_q <= 1'b0;
        else     was_data_q <= ahead_i[0];
    end

    // Data wins, then postamble, preamble, lead-in.
    always_comb begin
        if (ahead_i[0])      ph = PH_DATA;
        else if (was_data_q) ph = PH_POST;
        else if (ahead_i[1]) ph = PH_PRE;
        else if (ahead_i[2]) ph = PH_LEADIN;
        else                 ph = PH_IDLE;
        strobe_o = ph_to_strobe(ph);
    end

endmodule

// File: rtl/wbs_beat_reg.sv
module wbs_beat_reg #(
    parameter int DQ_W = 16,
    parameter int NB   = DQ_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [2*DQ_W-1:0] wdata_i,
    input  logic [2*NB-1:0]   wbe_i,
    output logic [2*DQ_W-1:0] dq_o,
    output logic [2*NB-1:0]   dm_o
);
    always_ff @(posedge clk) begin
        if (rst || !load_i) begin
            dq_o <= '0;
            dm_o <= '0;
        end else begin
            dq_o <= wdata_i;
            dm_o <= ~wbe_i;
        end
    end

endmodule

// File: rtl/wr_burst_seq.sv
module wr_burst_seq #(
    parameter int DQ_W = 16,
    parameter int AL_W = 3,
    parameter int CL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_i,
    input  logic                  cfg_bl8_i,
    input  logic [AL_W-1:0]       cfg_al_i,
    input  logic [CL_W-1:0]       cfg_cl_i,
    input  logic [2*DQ_W-1:0]     wdata_i,
    input  logic [2*DQ_W/8-1:0]   wbe_i,
    output logic                  wrdy_o,
    output logic [2*DQ_W-1:0]     dq_o,
    output logic [2*DQ_W/8-1:0]   dm_o,
    output logic [1:0]            dqs_o,
    output logic                  oe_o
);
    import wbs_pkg::*;

    localparam int NB     = DQ_W / 8;
    localparam int MAX_AL = (1 << AL_W) - 1;
    localparam int MAX_CL = (1 << CL_W) - 1;
    localparam int N      = MAX_AL + MAX_CL + 2;

    logic [N-1:0] sched;
    strobe_t      strobe;

    wbs_sched #(.AL_W(AL_W), .CL_W(CL_W), .N(N)) sched_i (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd_i),
        .bl8_i   (cfg_bl8_i),
        .al_i    (cfg_al_i),
        .cl_i    (cfg_cl_i),
        .sched_q (sched)
    );

    wbs_strobe_gen strobe_i (
        .clk      (clk),
        .rst      (rst),
        .ahead_i  (sched[2:0]),
        .strobe_o (strobe)
    );

    wbs_beat_reg #(.DQ_W(DQ_W), .NB(NB)) beat_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (sched[1]),
        .wdata_i (wdata_i),
        .wbe_i   (wbe_i),
        .dq_o    (dq_o),
        .dm_o    (dm_o)
    );

    assign wrdy_o = sched[1];
    assign dqs_o  = strobe.dqs;
    assign oe_o   = strobe.oe;

endmodule

// File: rtl/wr_burst_seq_chk.sv
module wr_burst_seq_chk #(
    parameter int DQ_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic [2*DQ_W/8-1:0] wbe_i,
    input logic                wrdy_o,
    input logic [2*DQ_W-1:0]   dq_o,
    input logic [2*DQ_W/8-1:0] dm_o,
    input logic [1:0]          dqs_o,
    input logic                oe_o
);
    logic is_data;
    assign is_data = (dqs_o == 2'b01);

    a_r8_req_then_data: assert property (@(posedge clk) disable iff (rst)
        wrdy_o |=> is_data);

    a_r8_data_after_req: assert property (@(posedge clk) disable iff (rst)
        is_data |-> $past(wrdy_o));

    a_r4_preamble: assert property (@(posedge clk) disable iff (rst)
        (is_data && !$past(is_data)) |-> ($past(oe_o) && $past(dqs_o) == 2'b00));

    a_r5_leadin: assert property (@(posedge clk) disable iff (rst)
        (is_data && !$past(is_data)) |-> $past(oe_o, 2));

    a_r6_postamble: assert property (@(posedge clk) disable iff (rst)
        (!is_data && $past(is_data)) |-> (oe_o && dqs_o == 2'b00));

    a_r7_mask: assert property (@(posedge clk) disable iff (rst)
        is_data |-> (dm_o == ~$past(wbe_i)));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !oe_o |-> (dq_o == '0 && dm_o == '0 && dqs_o == 2'b00));

    a_r10_reset: assert property (@(posedge clk)
        rst |=> (!oe_o && !wrdy_o && dqs_o == 2'b00));

endmodule

bind wr_burst_seq wr_burst_seq_chk #(.DQ_W(DQ_W)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .wbe_i  (wbe_i),
    .wrdy_o (wrdy_o),
    .dq_o   (dq_o),
    .dm_o   (dm_o),
    .dqs_o  (dqs_o),
    .oe_o   (oe_o)
);

// File: tb/wr_burst_seq_tb_top.sv
module wr_burst_seq_tb_top;
    localparam int DQ_W = 16;
    localparam int NB   = DQ_W / 8;
    localparam int MAXC = 8192;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cmd_i = 1'b0;
    logic                cfg_bl8_i = 1'b0;
    logic [2:0]          cfg_al_i = 3'd0;
    logic [2:0]          cfg_cl_i = 3'd4;
    logic [2*DQ_W-1:0]   wdata_i = '0;
    logic [2*NB-1:0]     wbe_i = '0;
    logic                wrdy_o;
    logic [2*DQ_W-1:0]   dq_o;
    logic [2*NB-1:0]     dm_o;
    logic [1:0]          dqs_o;
    logic                oe_o;

    always #2 clk = ~clk;

    wr_burst_seq #(.DQ_W(DQ_W), .AL_W(3), .CL_W(3)) dut_i (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .cfg_bl8_i(cfg_bl8_i),
        .cfg_al_i(cfg_al_i), .cfg_cl_i(cfg_cl_i), .wdata_i(wdata_i),
        .wbe_i(wbe_i), .wrdy_o(wrdy_o), .dq_o(dq_o), .dm_o(dm_o),
        .dqs_o(dqs_o), .oe_o(oe_o)
    );

    typedef struct {
        logic [2*DQ_W-1:0] d;
        logic [2*NB-1:0]   m;
    } item_t;

    item_t       sb_q[$];
    bit          exp_data[MAXC];
    bit          first_beat[MAXC];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int unsigned dcount = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // Issue one command; marks the expected data clocks from R1 and R3.
    task automatic issue();
        int wl, h, c;
        @(posedge clk);
        #1;
        cmd_i = 1'b1;
        c  = cyc;
        wl = int'(cfg_al_i) + int'(cfg_cl_i) - 1;
        h  = cfg_bl8_i ? 4 : 2;
        first_beat[c + wl] = 1'b1;
        for (int k = 0; k < h; k++) exp_data[c + wl + k] = 1'b1;
        @(posedge clk);
        #1;
        cmd_i = 1'b0;
    endtask

    task automatic set_cfg(bit bl8, int al, int cl);
        @(posedge clk);
        #1;
        cfg_bl8_i = bl8;
        cfg_al_i  = 3'(al);
        cfg_cl_i  = 3'(cl);
    endtask

    // Driver side: hand over data when requested and record the expectation.
    always @(negedge clk) begin
        if (!rst && wrdy_o) begin
            item_t it;
            dcount++;
            wdata_i = 32'(dcount * 32'h9E37_79B9);
            wbe_i   = 4'(dcount) ^ 4'h5;
            it.d = wdata_i;
            it.m = ~wbe_i;
            sb_q.push_back(it);
        end
    end

    // Monitor: per-clock phase model plus scoreboard compare.
    always @(negedge clk) begin
        if (!rst && !done) begin
            int  c;
            bit  d0, dp, dn1, dn2;
            string tag;
            c   = cyc;
            d0  = exp_data[c];
            dp  = (c > 0) ? exp_data[c - 1] : 1'b0;
            dn1 = exp_data[c + 1];
            dn2 = exp_data[c + 2];
            check(wrdy_o == dn1, "R8", "wrdy", 64'(wrdy_o), 64'(dn1));
            if (d0) begin
                if (first_beat[c] && dp) tag = "R9";
                else if (first_beat[c])  tag = "R1";
                else                     tag = "R3";
                check(oe_o && dqs_o == 2'b01, tag, "data strobe", 64'({oe_o, dqs_o}), 64'(3'b101));
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", "no queued beat", 64'(dq_o), 64'(0));
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(dq_o == it.d, "R2", "beats", 64'(dq_o), 64'(it.d));
                    check(dm_o == it.m, "R7", "mask", 64'(dm_o), 64'(it.m));
                end
            end else begin
                if (dp)       tag = "R6";
                else if (dn1) tag = "R4";
                else if (dn2) tag = "R5";
                else          tag = "R11";
                check(oe_o == (dp || dn1 || dn2) && dqs_o == 2'b00, tag, "strobe/oe",
                      64'({oe_o, dqs_o}), 64'({(dp || dn1 || dn2), 2'b00}));
                check(dq_o == '0 && dm_o == '0, "R11", "bus zero", 64'({dq_o, dm_o}), 64'(0));
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual cycle %0d expected completion earlier", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset
        check(!oe_o && !wrdy_o && dqs_o == 2'b00, "R10", "in reset",
              64'({oe_o, wrdy_o, dqs_o}), 64'(0));
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!oe_o && !wrdy_o && dqs_o == 2'b00, "R10", "after reset",
              64'({oe_o, wrdy_o, dqs_o}), 64'(0));

        // Single BL4, minimum latency WL=3
        set_cfg(1'b0, 0, 4);
        issue();
        idle(12);
        // Single BL8, WL=6
        set_cfg(1'b1, 2, 5);
        issue();
        idle(16);
        // Seamless BL4 x3 (spacing 2)
        set_cfg(1'b0, 1, 4);
        issue();
        issue();
        issue();
        idle(14);
        // Seamless BL8 x2 (spacing 4)
        set_cfg(1'b1, 0, 6);
        issue();
        idle(2);
        issue();
        idle(18);
        // BL4 with a single clock between data runs (spacing 3)
        set_cfg(1'b0, 2, 3);
        issue();
        idle(1);
        issue();
        idle(14);
        // BL4 with two clocks between data runs (spacing 4)
        set_cfg(1'b0, 0, 5);
        issue();
        idle(2);
        issue();
        idle(14);
        // Maximum latency WL=13, BL8
        set_cfg(1'b1, 7, 7);
        issue();
        idle(24);

        @(negedge clk);
        done = 1'b1;
        check(sb_q.size() == 0, "R8", "leftover beats", 64'(sb_q.size()), 64'(0));
        finish_run();
    end

endmodule